// File: doc/BRIEF.md
# Mixed-Length Instruction Field Decoder

This block sits right after instruction fetch. It takes the three bytes fetched at the current program counter and makes two decisions. It first works out whether the instruction is a 3-byte standard encoding or a 2-byte narrow encoding. It then splits out every operand field the later stages may need: opcode nibbles, the three register specifiers, and immediates in each of the packed formats. The immediates come out already sign-extended to the datapath width. It also produces the address of the following instruction. A narrow instruction fetched while the narrow-encoding option is switched off raises an illegal flag.

The nibble and byte positions of the fields depend on the byte order of the core, and a parameter picks that order at elaboration. The whole decoded bundle is captured into an output register whenever the fetch stage presents a valid word. The bundle then stays in step with the fetch handshake and holds its value while no new word arrives. Register-file reads, execution and memory access belong to other blocks.

Top module: `ifd_decoder`

## Requirements
- R1: With little-endian placement (BIG_ENDIAN=0), and byte0 = fetch_i[7:0], byte1 = fetch_i[15:8], byte2 = fetch_i[23:16]: op0 = byte0[3:0], t = byte0[7:4], s = byte1[3:0], r = byte1[7:4], op1 = byte2[3:0], op2 = byte2[7:4].
- R2: With big-endian placement (BIG_ENDIAN=1), the two nibbles of each byte trade places: op0 = byte0[7:4], t = byte0[3:0], s = byte1[7:4], r = byte1[3:0], op1 = byte2[7:4], op2 = byte2[3:0].
- R3: When op0 is 8 or more, the instruction is narrow (narrow_o=1) and next_pc_o = pc+2. Otherwise it is wide and next_pc_o = pc+3.
- R4: illegal_o is 1 exactly when the instruction is narrow and narrow_en_i is 0. A wide instruction is never illegal.
- R5: imm8_o is byte2, sign-extended from its bit 7.
- R6: imm16_o is {byte2, byte1} in little-endian placement and {byte1, byte2} in big-endian placement.
- R7: The call offset is 18 bits wide and is sign-extended from bit 17. In little-endian placement it is {byte2, byte1, byte0[7:6]} and call_n_o = byte0[5:4]. In big-endian placement it is {byte0[1:0], byte1, byte2} and call_n_o = byte0[3:2].
- R8: The branch immediate is 12 bits wide and is sign-extended from bit 11. In little-endian placement it is {byte2, byte1[7:4]} and m_o = byte0[7:6]. In big-endian placement it is {byte1[3:0], byte2} and m_o = byte0[1:0].
- R9: addi_o is the t field zero-extended. The one exception is t = 0, which gives all ones (-1).
- R10: movi_o is {t, r} zero-extended. When t[2:1] is 2'b11, bits [DATA_W-1:7] are forced to 1.
- R11: out_valid_o is in_valid_i delayed by one clock. Decoded outputs update only on a clock edge where in_valid_i is 1, and hold otherwise.
- R12: While rst_n is low, out_valid_o and every decoded output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Fetch word valid; enables capture |
| narrow_en_i | input | 1 | Narrow-encoding option enabled |
| pc_i | input | PC_W | Address of the fetched instruction |
| fetch_i | input | 24 | Three fetched bytes, byte0 in the low bits |
| out_valid_o | output | 1 | Decoded bundle valid |
| op0_o | output | 4 | Major opcode |
| op1_o | output | 4 | First sub-opcode |
| op2_o | output | 4 | Second sub-opcode |
| reg_r_o | output | 4 | r register specifier |
| reg_s_o | output | 4 | s register specifier |
| reg_t_o | output | 4 | t register specifier |
| narrow_o | output | 1 | Instruction is 2 bytes long |
| illegal_o | output | 1 | Narrow instruction with the option off |
| next_pc_o | output | PC_W | Address of the following instruction |
| imm8_o | output | DATA_W | Sign-extended 8-bit immediate |
| imm16_o | output | 16 | 16-bit immediate |
| imm12_o | output | DATA_W | Sign-extended branch immediate |
| call_ofs_o | output | DATA_W | Sign-extended call offset |
| call_n_o | output | 2 | Call-type field |
| m_o | output | 2 | m field |
| addi_o | output | DATA_W | Narrow add-immediate value |
| movi_o | output | DATA_W | Narrow move-immediate value |

## Verification
The bench drives two instances side by side, one for each byte order, from the same stimulus. A nibble swap or a byte swap applied to only one layout therefore shows up as a field mismatch on that instance alone. Directed words sit on the op0 = 7/8 boundary with the option both off and on. A decoder that splits the length at the wrong value reports the wrong next_pc and a wrong illegal flag. Other directed words set the top bit of each immediate, which exposes extension from the wrong bit as a sign error in the upper bits. The add-immediate is driven with t = 0, and the move-immediate with t = 5, 6 and 7, to catch a missing special value and a misplaced extension condition. A cycle with valid low and fresh bytes on the bus shows whether the output register captures without its enable.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
  localparam int BYTE_W     = 8;
  localparam int NIB_W      = 4;
  localparam int INSN_BYTES = 3;
  localparam int INSN_W     = BYTE_W * INSN_BYTES;
  localparam int CALL_W     = 18;
  localparam int BR12_W     = 12;
  localparam int IMM16_W    = 16;
  localparam int NARROW_MIN = 8;
  localparam int WIDE_LEN   = 3;
  localparam int NARROW_LEN = 2;

  typedef struct packed {
    logic [NIB_W-1:0]   op0;
    logic [NIB_W-1:0]   op1;
    logic [NIB_W-1:0]   op2;
    logic [NIB_W-1:0]   r;
    logic [NIB_W-1:0]   s;
    logic [NIB_W-1:0]   t;
    logic [1:0]         call_n;
    logic [1:0]         m;
    logic [BYTE_W-1:0]  imm8_raw;
    logic [IMM16_W-1:0] imm16;
    logic [CALL_W-1:0]  call_raw;
    logic [BR12_W-1:0]  br_raw;
  } fields_t;
endpackage

// File: rtl/ifd_field_split.sv
module ifd_field_split
  import ifd_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic [INSN_W-1:0] word_i,
  output fields_t           fld_o
);
  logic [BYTE_W-1:0] b0, b1, b2;

  always_comb begin
    b0 = word_i[BYTE_W-1:0];
    b1 = word_i[2*BYTE_W-1:BYTE_W];
    b2 = word_i[3*BYTE_W-1:2*BYTE_W];
  end

  generate
    if (BIG_ENDIAN) begin : g_be
      always_comb begin
        fld_o.op0      = b0[7:4];
        fld_o.t        = b0[3:0];
        fld_o.s        = b1[7:4];
        fld_o.r        = b1[3:0];
        fld_o.op1      = b2[7:4];
        fld_o.op2      = b2[3:0];
        fld_o.call_n   = b0[3:2];
        fld_o.m        = b0[1:0];
        fld_o.imm8_raw = b2;
        fld_o.imm16    = {b1, b2};
        fld_o.call_raw = {b0[1:0], b1, b2};
        fld_o.br_raw   = {b1[3:0], b2};
      end
    end else begin : g_le
      always_comb begin
        fld_o.op0      = b0[3:0];
        fld_o.t        = b0[7:4];
        fld_o.s        = b1[3:0];
        fld_o.r        = b1[7:4];
        fld_o.op1      = b2[3:0];
        fld_o.op2      = b2[7:4];
        fld_o.call_n   = b0[5:4];
        fld_o.m        = b0[7:6];
        fld_o.imm8_raw = b2;
        fld_o.imm16    = {b2, b1};
        fld_o.call_raw = {b2, b1, b0[7:6]};
        fld_o.br_raw   = {b2, b1[7:4]};
      end
    end
  endgenerate
endmodule

// File: rtl/ifd_imm_build.sv
module ifd_imm_build
  import ifd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fields_t           fld_i,
  output logic [DATA_W-1:0] imm8_o,
  output logic [DATA_W-1:0] imm12_o,
  output logic [DATA_W-1:0] call_o,
  output logic [DATA_W-1:0] addi_o,
  output logic [DATA_W-1:0] movi_o
);
  localparam logic [DATA_W-1:0] MOVI_LOW  = DATA_W'(7'h7f);
  localparam logic [DATA_W-1:0] MOVI_FILL = ~MOVI_LOW;

  logic [DATA_W-1:0] movi_base;

  always_comb begin
    imm8_o  = {{(DATA_W-BYTE_W){fld_i.imm8_raw[BYTE_W-1]}}, fld_i.imm8_raw};
    imm12_o = {{(DATA_W-BR12_W){fld_i.br_raw[BR12_W-1]}}, fld_i.br_raw};
    call_o  = {{(DATA_W-CALL_W){fld_i.call_raw[CALL_W-1]}}, fld_i.call_raw};

    if (fld_i.t == '0) addi_o = '1;
    else               addi_o = DATA_W'(fld_i.t);

    movi_base = DATA_W'({fld_i.t, fld_i.r});
    if (fld_i.t[2:1] == 2'b11) movi_o = movi_base | MOVI_FILL;
    else                       movi_o = movi_base;
  end
endmodule

// File: rtl/ifd_len_check.sv
module ifd_len_check
  import ifd_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic [NIB_W-1:0] op0_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             narrow_en_i,
  output logic             narrow_o,
  output logic             illegal_o,
  output logic [PC_W-1:0]  next_pc_o
);
  localparam logic [NIB_W-1:0] SPLIT = NIB_W'(NARROW_MIN);

  always_comb begin
    narrow_o  = (op0_i >= SPLIT);
    illegal_o = narrow_o && !narrow_en_i;
    next_pc_o = pc_i + (narrow_o ? PC_W'(NARROW_LEN) : PC_W'(WIDE_LEN));
  end
endmodule

// File: rtl/ifd_decoder.sv
module ifd_decoder
  import ifd_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b0,
  parameter int PC_W       = 32,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic              narrow_en_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [23:0]       fetch_i,
  output logic              out_valid_o,
  output logic [3:0]        op0_o,
  output logic [3:0]        op1_o,
  output logic [3:0]        op2_o,
  output logic [3:0]        reg_r_o,
  output logic [3:0]        reg_s_o,
  output logic [3:0]        reg_t_o,
  output logic              narrow_o,
  output logic              illegal_o,
  output logic [PC_W-1:0]   next_pc_o,
  output logic [DATA_W-1:0] imm8_o,
  output logic [15:0]       imm16_o,
  output logic [DATA_W-1:0] imm12_o,
  output logic [DATA_W-1:0] call_ofs_o,
  output logic [1:0]        call_n_o,
  output logic [1:0]        m_o,
  output logic [DATA_W-1:0] addi_o,
  output logic [DATA_W-1:0] movi_o
);
  fields_t           fld;
  logic              narrow_d, illegal_d;
  logic [PC_W-1:0]   npc_d;
  logic [DATA_W-1:0] imm8_d, imm12_d, call_d, addi_d, movi_d;

  ifd_field_split #(.BIG_ENDIAN(BIG_ENDIAN)) u_split (
    .word_i (fetch_i),
    .fld_o  (fld)
  );

  ifd_imm_build #(.DATA_W(DATA_W)) u_imm (
    .fld_i   (fld),
    .imm8_o  (imm8_d),
    .imm12_o (imm12_d),
    .call_o  (call_d),
    .addi_o  (addi_d),
    .movi_o  (movi_d)
  );

  ifd_len_check #(.PC_W(PC_W)) u_len (
    .op0_i       (fld.op0),
    .pc_i        (pc_i),
    .narrow_en_i (narrow_en_i),
    .narrow_o    (narrow_d),
    .illegal_o   (illegal_d),
    .next_pc_o   (npc_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid_o <= 1'b0;
    else        out_valid_o <= in_valid_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op0_o      <= '0;
      op1_o      <= '0;
      op2_o      <= '0;
      reg_r_o    <= '0;
      reg_s_o    <= '0;
      reg_t_o    <= '0;
      narrow_o   <= 1'b0;
      illegal_o  <= 1'b0;
      next_pc_o  <= '0;
      imm8_o     <= '0;
      imm16_o    <= '0;
      imm12_o    <= '0;
      call_ofs_o <= '0;
      call_n_o   <= '0;
      m_o        <= '0;
      addi_o     <= '0;
      movi_o     <= '0;
    end else if (in_valid_i) begin
      op0_o      <= fld.op0;
      op1_o      <= fld.op1;
      op2_o      <= fld.op2;
      reg_r_o    <= fld.r;
      reg_s_o    <= fld.s;
      reg_t_o    <= fld.t;
      narrow_o   <= narrow_d;
      illegal_o  <= illegal_d;
      next_pc_o  <= npc_d;
      imm8_o     <= imm8_d;
      imm16_o    <= fld.imm16;
      imm12_o    <= imm12_d;
      call_ofs_o <= call_d;
      call_n_o   <= fld.call_n;
      m_o        <= fld.m;
      addi_o     <= addi_d;
      movi_o     <= movi_d;
    end
  end
endmodule

// File: rtl/ifd_decoder_chk.sv
module ifd_decoder_chk #(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid_i,
  input logic              narrow_en_i,
  input logic [PC_W-1:0]   pc_i,
  input logic              out_valid_o,
  input logic [3:0]        op0_o,
  input logic              narrow_o,
  input logic              illegal_o,
  input logic [PC_W-1:0]   next_pc_o,
  input logic [DATA_W-1:0] imm8_o,
  input logic [15:0]       imm16_o,
  input logic [DATA_W-1:0] addi_o,
  input logic [DATA_W-1:0] movi_o
);
  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_valid_o);
  assert_idle_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> !out_valid_o);
  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> ($stable(imm16_o) && $stable(next_pc_o) && $stable(op0_o)));
  assert_length_split_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (narrow_o == (op0_o >= 4'd8)));
  assert_next_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> (next_pc_o == $past(pc_i) + (narrow_o ? PC_W'(2) : PC_W'(3))));
  assert_illegal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> (illegal_o == (narrow_o && !$past(narrow_en_i))));
  assert_imm8_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (imm8_o[DATA_W-1:8] == {(DATA_W-8){imm8_o[7]}}));
  assert_addi_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (addi_o != '0));
  assert_movi_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> ((movi_o[DATA_W-1:8] == '0) || (movi_o[DATA_W-1:8] == '1)));
endmodule

bind ifd_decoder ifd_decoder_chk #(.PC_W(PC_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid_i  (in_valid_i),
  .narrow_en_i (narrow_en_i),
  .pc_i        (pc_i),
  .out_valid_o (out_valid_o),
  .op0_o       (op0_o),
  .narrow_o    (narrow_o),
  .illegal_o   (illegal_o),
  .next_pc_o   (next_pc_o),
  .imm8_o      (imm8_o),
  .imm16_o     (imm16_o),
  .addi_o      (addi_o),
  .movi_o      (movi_o)
);

// File: tb/tb_ifd_decoder.sv
module tb_ifd_decoder;
  typedef struct packed {
    logic        valid;
    logic [3:0]  op0, op1, op2, r, s, t;
    logic        narrow, illegal;
    logic [31:0] npc, imm8;
    logic [15:0] imm16;
    logic [31:0] imm12, call;
    logic [1:0]  call_n, m;
    logic [31:0] addi, movi;
  } obs_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        en;
  logic [31:0] pc;
  logic [23:0] word;
  obs_t        le_obs, be_obs;
  int          n_checks = 0;
  int          n_fails  = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ifd_decoder #(.BIG_ENDIAN(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .narrow_en_i(en),
    .pc_i(pc), .fetch_i(word), .out_valid_o(le_obs.valid),
    .op0_o(le_obs.op0), .op1_o(le_obs.op1), .op2_o(le_obs.op2),
    .reg_r_o(le_obs.r), .reg_s_o(le_obs.s), .reg_t_o(le_obs.t),
    .narrow_o(le_obs.narrow), .illegal_o(le_obs.illegal), .next_pc_o(le_obs.npc),
    .imm8_o(le_obs.imm8), .imm16_o(le_obs.imm16), .imm12_o(le_obs.imm12),
    .call_ofs_o(le_obs.call), .call_n_o(le_obs.call_n), .m_o(le_obs.m),
    .addi_o(le_obs.addi), .movi_o(le_obs.movi)
  );

  ifd_decoder #(.BIG_ENDIAN(1'b1)) dut_be (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .narrow_en_i(en),
    .pc_i(pc), .fetch_i(word), .out_valid_o(be_obs.valid),
    .op0_o(be_obs.op0), .op1_o(be_obs.op1), .op2_o(be_obs.op2),
    .reg_r_o(be_obs.r), .reg_s_o(be_obs.s), .reg_t_o(be_obs.t),
    .narrow_o(be_obs.narrow), .illegal_o(be_obs.illegal), .next_pc_o(be_obs.npc),
    .imm8_o(be_obs.imm8), .imm16_o(be_obs.imm16), .imm12_o(be_obs.imm12),
    .call_ofs_o(be_obs.call), .call_n_o(be_obs.call_n), .m_o(be_obs.m),
    .addi_o(be_obs.addi), .movi_o(be_obs.movi)
  );

  function automatic obs_t model(bit be, logic [23:0] w, logic [31:0] p, bit opt);
    obs_t o;
    logic [7:0] b0, b1, b2;
    int cv, bv, iv;
    b0 = w[7:0]; b1 = w[15:8]; b2 = w[23:16];
    o.valid = 1'b1;
    if (be) begin
      o.op0 = b0[7:4]; o.t = b0[3:0]; o.s = b1[7:4]; o.r = b1[3:0];
      o.op1 = b2[7:4]; o.op2 = b2[3:0];
      o.imm16 = {b1, b2};
      cv = int'(b0[1:0]) * 65536 + int'(b1) * 256 + int'(b2);
      bv = int'(b1[3:0]) * 256 + int'(b2);
      o.call_n = b0[3:2]; o.m = b0[1:0];
    end else begin
      o.op0 = b0[3:0]; o.t = b0[7:4]; o.s = b1[3:0]; o.r = b1[7:4];
      o.op1 = b2[3:0]; o.op2 = b2[7:4];
      o.imm16 = {b2, b1};
      cv = int'(b0[7:6]) + int'(b1) * 4 + int'(b2) * 1024;
      bv = int'(b1[7:4]) + int'(b2) * 16;
      o.call_n = b0[5:4]; o.m = b0[7:6];
    end
    if (cv >= 131072) cv = cv - 262144;
    if (bv >= 2048)   bv = bv - 4096;
    iv = int'(b2);
    if (iv >= 128) iv = iv - 256;
    o.call  = 32'(cv);
    o.imm12 = 32'(bv);
    o.imm8  = 32'(iv);
    o.narrow  = (o.op0 > 4'd7);
    o.illegal = o.narrow && !opt;
    o.npc     = p + (o.narrow ? 32'd2 : 32'd3);
    o.addi    = (o.t == 4'd0) ? 32'hffff_ffff : {28'd0, o.t};
    o.movi    = {24'd0, o.t, o.r};
    if (o.t[2] && o.t[1]) o.movi = o.movi | 32'hffff_ff80;
    return o;
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_side(input bit be, input obs_t a, input obs_t e);
    string lay;
    lay = be ? "R2" : "R1";
    cmp({lay, " op0"}, 32'(a.op0), 32'(e.op0));
    cmp({lay, " op1"}, 32'(a.op1), 32'(e.op1));
    cmp({lay, " op2"}, 32'(a.op2), 32'(e.op2));
    cmp({lay, " r"},   32'(a.r),   32'(e.r));
    cmp({lay, " s"},   32'(a.s),   32'(e.s));
    cmp({lay, " t"},   32'(a.t),   32'(e.t));
    cmp("R3 narrow",   32'(a.narrow), 32'(e.narrow));
    cmp("R3 next_pc",  a.npc, e.npc);
    cmp("R4 illegal",  32'(a.illegal), 32'(e.illegal));
    cmp("R5 imm8",     a.imm8, e.imm8);
    cmp("R6 imm16",    32'(a.imm16), 32'(e.imm16));
    cmp("R7 call_ofs", a.call, e.call);
    cmp("R7 call_n",   32'(a.call_n), 32'(e.call_n));
    cmp("R8 imm12",    a.imm12, e.imm12);
    cmp("R8 m",        32'(a.m), 32'(e.m));
    cmp("R9 addi",     a.addi, e.addi);
    cmp("R10 movi",    a.movi, e.movi);
    cmp("R11 valid",   32'(a.valid), 32'(e.valid));
  endtask

  obs_t last_le, last_be;

  task automatic apply(input logic [23:0] w, input logic [31:0] p, input bit opt);
    word = w; pc = p; en = opt; in_valid = 1'b1;
    @(negedge clk);
    last_le = model(1'b0, w, p, opt);
    last_be = model(1'b1, w, p, opt);
    check_side(1'b0, le_obs, last_le);
    check_side(1'b1, be_obs, last_be);
  endtask

  task automatic check_hold(input logic [23:0] w);
    obs_t ele, ebe;
    word = w; pc = ~pc; en = ~en; in_valid = 1'b0;
    @(negedge clk);
    ele = last_le; ele.valid = 1'b0;
    ebe = last_be; ebe.valid = 1'b0;
    n_checks++;
    if (le_obs !== ele) begin
      n_fails++;
      $display("FAIL R11 hold le actual=%h expected=%h", le_obs, ele);
    end
    n_checks++;
    if (be_obs !== ebe) begin
      n_fails++;
      $display("FAIL R11 hold be actual=%h expected=%h", be_obs, ebe);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; en = 1'b1; pc = 32'h0000_1000; word = 24'hff_ffff;
    repeat (2) @(negedge clk);
    // R12: reset state with non-zero inputs present
    cmp("R12 reset le", 32'(le_obs.valid) | le_obs.npc | le_obs.call | le_obs.addi | 32'(le_obs.op0),
        32'd0);
    cmp("R12 reset be", 32'(be_obs.valid) | be_obs.movi | be_obs.imm8 | 32'(be_obs.imm16),
        32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners
    apply(24'h00_000B, 32'h0000_2000, 1'b1); // R9 narrow add-immediate t=0
    apply(24'h00_506C, 32'h0000_2002, 1'b1); // R10 t=6 fill
    apply(24'h00_507C, 32'h0000_2004, 1'b1); // R10 t=7 fill
    apply(24'h00_505C, 32'h0000_2006, 1'b1); // R10 t=5 no fill
    apply(24'h12_3407, 32'h0000_3000, 1'b0); // R3/R4 op0=7 wide, option off
    apply(24'h12_3408, 32'h0000_3000, 1'b0); // R3/R4 op0=8 narrow, option off
    apply(24'h12_3408, 32'h0000_3000, 1'b1); // R4 option on
    apply(24'h80_0005, 32'h0000_4000, 1'b1); // R7 most negative call offset
    apply(24'h7F_FFC5, 32'h0000_4000, 1'b1); // R7 most positive call offset
    apply(24'hFF_F002, 32'h0000_5000, 1'b1); // R8 branch immediate -1 / R5
    apply(24'h7F_0F80, 32'hFFFF_FFFE, 1'b1); // R5/R6 positive byte, pc wrap
    check_hold(24'hA5_5A3C);                 // R11 hold with valid low
    apply(24'h01_2345, 32'h0000_6000, 1'b1); // R1/R2 distinct nibbles
    check_hold(24'h00_0000);                 // R11

    // Random stimulus
    for (int i = 0; i < 600; i++) begin
      apply(24'($urandom), $urandom, 1'($urandom));
      if (($urandom % 8) == 0) check_hold(24'($urandom));
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule